// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Port

This block moves one byte at a time over a two-wire synchronous link made of a shift clock and a bidirectional data line. The block is always the clock master. The link is half duplex. A transmit transfer drives the data line through an output enable. A receive transfer leaves the line undriven and samples it. The speed is set by a compare value `n`, and one bit period lasts `n+1` system clocks.

The shift clock is deliberately asymmetric. For `n` of 2 or more, each bit opens with a fixed two-clock low phase, followed by `n-1` clocks high. Outgoing data stays put for two clocks after each rising edge and is then replaced. This leaves `n-1` clocks of setup before the next rising edge. For `n` equal to 1, the clock is one clock low and one clock high, and data gets one clock of setup and one clock of hold.

Software-facing control is a small register port. It has a compare input, a transmit-byte write strobe, a direction select, a start pulse, a one-cycle done flag, a busy level and the received byte.

Top module: `ssp_sync_serial`

## Requirements
- R1: The bit period of `sclk` is `n+1` system clocks, where `n` is the compare value. `sclk` rests at 1 while idle and stays at 1 from the last rising edge of a transfer onward.
- R2: For `n >= 2`, every low phase of `sclk` lasts exactly 2 clocks and every high phase inside a transfer lasts `n-1` clocks.
- R3: For `n == 1`, every low phase and every high phase of `sclk` inside a transfer lasts exactly 1 clock.
- R4: A compare value of 0 gives the same waveforms as a compare value of 1.
- R5: A transmit transfer (`cfg_rx` = 0) sends 8 bits, least significant bit first. Bit 0 is on `sd_o` from the cycle after the accepted start. Each later bit replaces the previous one 2 clocks after the preceding rising edge when `n >= 2`, and 1 clock after it when `n == 1`. `sd_o` never changes in the cycle in which `sclk` goes high.
- R6: In a transmit transfer, `sd_oe` = 1 (driving) holds from the cycle after the start through the cycle of the eighth rising edge, and `sd_oe` = 0 from the following cycle. A receive transfer keeps `sd_oe` at 0 throughout.
- R7: A receive transfer (`cfg_rx` = 1) captures `sd_i` at the system-clock edge that makes `sclk` go high, least significant bit first. No hold time is needed after that edge. The byte appears on `rx_rdata` in the done cycle. A transmit transfer leaves `rx_rdata` unchanged.
- R8: `busy` is 1 from the cycle after an accepted start through the cycle of the eighth rising edge. `done` is 1 for exactly the following cycle.
- R9: A `start` pulse while `busy` is 1 is ignored, and the running transfer keeps its timing.
- R10: A change of `cfg_cmp` or a write through `tx_wr` during a transfer affects only the next transfer.
- R11: After reset, `sclk` = 1, `sd_oe` = 0, `busy` = 0, `done` = 0 and `rx_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cmp | input | CMP_W | Compare value `n`, latched at start |
| cfg_rx | input | 1 | Direction for the next start: 1 receive, 0 transmit |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| tx_wdata | input | DATA_W | Transmit byte written on `tx_wr` |
| start | input | 1 | Start request, honoured only when idle |
| rx_rdata | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle end-of-transfer flag |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Shift clock |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line input value |

## Verification
The bench sweeps compare values from 0 through 6, plus 13 and 255. For every cycle of every transfer it predicts the clock level, the data bit and the enable from period arithmetic. A design that mishandled the `n == 1` case or the zero value would show a two-clock low phase where one is due. A design that counted the hold from the wrong edge would move data one cycle early or late, and that breaks the setup count. Receive stimulus changes the line right after the capturing edge, so a design that sampled one cycle late would shift in the neighbouring bit. Mid-transfer start pulses, compare changes and transmit writes are injected; a design that honoured them would stretch or restart the waveform or send the wrong byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } ssp_state_e;

    // Latched per-transfer configuration.
    typedef struct packed {
        logic rx_mode;
        logic two_low;
    } ssp_xfer_s;

    // Low-phase length, which is also the data hold after a rising edge.
    function automatic logic [1:0] edge_gap(input logic two_low);
        return two_low ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int CMP_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic             two_low,
    input  logic [CMP_W-1:0] n_q,
    output logic             sclk,
    output logic             rise_tick,
    output logic             last_rise
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [CMP_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic [CMP_W-1:0] low_len;
    logic             wrap;

    assign low_len = CMP_W'(edge_gap(two_low));
    assign wrap    = (cnt_q == n_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else if (run) begin
            if (wrap) begin
                cnt_q <= '0;
                bit_q <= bit_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Each bit slot opens with its low phase; the clock rests high otherwise.
    assign sclk      = !run || (cnt_q >= low_len);
    assign rise_tick = run && (cnt_q == low_len - 1'b1);
    assign last_rise = rise_tick && (bit_q == LAST_BIT);

    p_low_two_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && two_low) |=> (!sclk ##1 sclk));

    p_low_one_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && !two_low) |=> sclk);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= n_q));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              cfg_rx,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rise_tick,
    input  logic              last_rise,
    input  logic              finish,
    input  logic              two_low,
    input  logic              sd_i,
    output logic              sd_o,
    output logic              sd_oe,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] txsh_q;
    logic [DATA_W-1:0] rxsh_q;
    logic [DATA_W-1:0] rx_q;
    logic              rx_mode_q;
    logic [1:0]        hold_q;
    logic              out_q;
    logic              oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            txsh_q    <= '0;
            rxsh_q    <= '0;
            rx_q      <= '0;
            rx_mode_q <= 1'b0;
            hold_q    <= '0;
            out_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            if (load) begin
                rx_mode_q <= cfg_rx;
                out_q     <= tx_byte[0];
                txsh_q    <= tx_byte >> 1;
                oe_q      <= !cfg_rx;
                hold_q    <= '0;
            end else begin
                // Hold timer: armed at a rise, advances the bit when it expires.
                if (rise_tick && !last_rise)
                    hold_q <= edge_gap(two_low);
                else if (hold_q != 2'd0)
                    hold_q <= hold_q - 2'd1;
                if (hold_q == 2'd1) begin
                    out_q  <= txsh_q[0];
                    txsh_q <= txsh_q >> 1;
                end
                if (finish)
                    oe_q <= 1'b0;
            end
            if (rise_tick && rx_mode_q)
                rxsh_q <= {sd_i, rxsh_q[DATA_W-1:1]};
            if (finish && rx_mode_q)
                rx_q <= rxsh_q;
        end
    end

    assign sd_o    = out_q;
    assign sd_oe   = oe_q;
    assign rx_byte = rx_q;

    p_oe_release_r6: assert property (@(posedge clk) disable iff (rst)
        finish |=> !sd_oe);

    p_rx_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (finish && !rx_mode_q) |=> $stable(rx_byte));

endmodule

// File: rtl/ssp_sync_serial.sv
module ssp_sync_serial
    import ssp_pkg::*;
#(
    parameter int CMP_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMP_W-1:0]  cfg_cmp,
    input  logic              cfg_rx,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              start,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              done,
    output logic              busy,
    output logic              sclk,
    output logic              sd_o,
    output logic              sd_oe,
    input  logic              sd_i
);
    ssp_state_e        state_q;
    logic [CMP_W-1:0]  n_q;
    logic [CMP_W-1:0]  n_eff;
    ssp_xfer_s         xf_q;
    logic [DATA_W-1:0] txbuf_q;
    logic              done_q;
    logic              go;
    logic              run;
    logic              finish;
    logic              rise_tick;
    logic              last_rise;

    // A zero compare value is promoted to one.
    assign n_eff  = (cfg_cmp == '0) ? CMP_W'(1) : cfg_cmp;
    assign go     = start && (state_q == ST_IDLE);
    assign run    = (state_q == ST_SHIFT);
    assign finish = (state_q == ST_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            n_q     <= CMP_W'(1);
            xf_q    <= '0;
            txbuf_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (tx_wr)
                txbuf_q <= tx_wdata;
            case (state_q)
                ST_IDLE: if (go) begin
                    state_q      <= ST_SHIFT;
                    n_q          <= n_eff;
                    xf_q.rx_mode <= cfg_rx;
                    xf_q.two_low <= (n_eff != CMP_W'(1));
                end
                ST_SHIFT: if (last_rise) state_q <= ST_TAIL;
                ST_TAIL:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    ssp_clkgen #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .load      (go),
        .run       (run),
        .two_low   (xf_q.two_low),
        .n_q       (n_q),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .last_rise (last_rise)
    );

    ssp_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .load      (go),
        .cfg_rx    (cfg_rx),
        .tx_byte   (txbuf_q),
        .rise_tick (rise_tick),
        .last_rise (last_rise),
        .finish    (finish),
        .two_low   (xf_q.two_low),
        .sd_i      (sd_i),
        .sd_o      (sd_o),
        .sd_oe     (sd_oe),
        .rx_byte   (rx_rdata)
    );

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    p_hold_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk) && sd_oe) |-> $stable(sd_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(n_q));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!sd_oe && sclk));

endmodule

// File: tb/sim_ssp_sync_serial.sv
`timescale 1ns/1ps
module sim_ssp_sync_serial;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cfg_cmp;
    logic       cfg_rx;
    logic       tx_wr;
    logic [7:0] tx_wdata;
    logic       start;
    logic       sd_i;
    logic [7:0] rx_rdata;
    logic       done, busy, sclk, sd_o, sd_oe;

    int         errors = 0;
    int         checks = 0;
    logic [7:0] rx_prev = 8'h00;

    always #5 clk = ~clk;

    ssp_sync_serial #(.CMP_W(8), .DATA_W(8)) u0 (
        .clk(clk), .rst(rst), .cfg_cmp(cfg_cmp), .cfg_rx(cfg_rx),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .start(start),
        .rx_rdata(rx_rdata), .done(done), .busy(busy), .sclk(sclk),
        .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic string ntag(input int nraw);
        if (nraw == 0) return "R4";
        if (nraw == 1) return "R3";
        return "R2";
    endfunction

    task automatic wr_tx(input logic [7:0] b);
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // One transfer; every cycle is compared against period arithmetic.
    task automatic xfer(input int nraw, input bit rxm, input logic [7:0] txb,
                        input logic [7:0] rxb, input bit poke, input logic [7:0] poke_tx);
        int ne, lo, per, last;
        string ctag;
        ne   = (nraw == 0) ? 1 : nraw;
        lo   = (ne == 1) ? 1 : 2;
        per  = ne + 1;
        last = 7 * per + lo;
        ctag = poke ? "R10" : ntag(nraw);
        @(negedge clk);
        cfg_cmp = nraw[7:0]; cfg_rx = rxm; start = 1'b1; sd_i = rxb[0];
        @(posedge clk);
        for (int t = 0; t <= last + 2; t++) begin
            @(negedge clk);
            start = 1'b0;
            tx_wr = 1'b0;
            if (poke && t == 3) begin
                start = 1'b1;               // R9: ignored while busy
                cfg_cmp = cfg_cmp ^ 8'hFF;  // R10: next transfer only
                tx_wr = 1'b1; tx_wdata = poke_tx;
            end
            if (t <= last)
                chk(ctag, "sclk", sclk, ((t % per) >= lo) ? 1 : 0);
            else
                chk("R1", "sclk idle", sclk, 1);
            chk(poke ? "R9" : "R8", "busy", busy, (t <= last) ? 1 : 0);
            chk(poke ? "R9" : "R8", "done", done, (t == last + 1) ? 1 : 0);
            chk("R6", "sd_oe", sd_oe, (!rxm && t <= last) ? 1 : 0);
            if (!rxm && t <= last) begin
                int k = 0;
                for (int kk = 1; kk < 8; kk++)
                    if ((kk - 1) * per + lo + lo <= t) k = kk;
                chk(poke ? "R10" : "R5", "sd_o", sd_o, txb[k]);
            end
            if (t == last + 1) begin
                if (rxm) rx_prev = rxb;
                chk("R7", "rx_rdata", rx_rdata, rx_prev);
            end
            if (t <= last) begin
                int kr = 0;
                while (kr < 7 && kr * per + lo - 1 < t) kr++;
                sd_i = rxb[kr];
            end
        end
        tx_wr = 1'b0;
    endtask

    initial begin
        #1_500_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_cmp = 8'd2; cfg_rx = 1'b0; tx_wr = 1'b0;
        tx_wdata = 8'h00; start = 1'b0; sd_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "sclk", sclk, 1);
        chk("R11", "sd_oe", sd_oe, 0);
        chk("R11", "busy", busy, 0);
        chk("R11", "done", done, 0);
        chk("R11", "rx_rdata", rx_rdata, 0);

        foreach (sweep[i]) begin
            logic [7:0] tb_byte, rb;
            tb_byte = 8'hA5 ^ 8'(sweep[i] * 37);
            rb      = 8'h3C ^ 8'(sweep[i] * 91);
            wr_tx(tb_byte);
            xfer(sweep[i], 1'b0, tb_byte, 8'h00, 1'b0, 8'h00);
            xfer(sweep[i], 1'b1, tb_byte, rb, 1'b0, 8'h00);
            wr_tx(~tb_byte);
            xfer(sweep[i], 1'b0, ~tb_byte, 8'h00, 1'b0, 8'h00);
            xfer(sweep[i], 1'b1, ~tb_byte, ~rb, 1'b0, 8'h00);
        end

        // Mid-transfer start, compare change and transmit write.
        wr_tx(8'h96);
        xfer(4, 1'b0, 8'h96, 8'h00, 1'b1, 8'h2D);
        xfer(4, 1'b0, 8'h2D, 8'h00, 1'b0, 8'h00);
        xfer(2, 1'b1, 8'h2D, 8'hB1, 1'b1, 8'h71);
        xfer(1, 1'b0, 8'h71, 8'h00, 1'b0, 8'h00);

        // Longest period.
        wr_tx(8'h6E);
        xfer(255, 1'b0, 8'h6E, 8'h00, 1'b0, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int sweep[8] = '{0, 1, 2, 3, 4, 5, 6, 13};

endmodule